// File: doc/BRIEF.md
# Serial Audio Output Port

This block is the transmit side of a slave-mode serial audio port. It receives six signed 24-bit samples, two per data line, and shifts them out on three data lines. The bit clock and the frame clock both come from outside. The block runs in a faster system clock domain and finds the falling bit-clock edges by comparing each bit-clock sample with the one before it. Two independent selects set the framing. One chooses the bit layout inside each half frame: MSB-justified, I2S-style, or LSB-justified. The other chooses the word length: 16, 18, 20 or 24 bits.

Each sample is truncated to the chosen word length. When dither is on, a 16-bit LFSR supplies a pseudo-random bit, and that bit is added at the LSB of the truncated word. The addition saturates: it clips at the largest positive word and never wraps. A channel-mode input can force the third line low, which leaves only four channels active. During reset, and whenever the layout code is the reserved value, every data line is held low.

Top module: `serial_audio_tx`

## Requirements
- R1: The block registers the bit clock in the system clock. A falling bit-clock edge is a cycle where the registered bit clock is 1 and the live bit clock is 0; it updates the slot counter in that cycle, and the data lines show the bit for that slot one system cycle later. Bits go out MSB first, in two's complement.
- R2: The slot counter restarts at 0 on a falling edge where the frame clock differs from its value at the previous falling edge, taken as 0 after reset. Otherwise it counts up and saturates at 63. Layout code 2 (MSB-justified): slot k carries word bit k, counted from the MSB.
- R3: Layout code 3 (I2S-style): slot 0 is low and slot k carries word bit k-1, counted from the MSB. In this layout the left channel goes with frame clock low. In every other layout it goes with frame clock high.
- R4: Layout code 0 (LSB-justified) uses a fixed 32-slot half frame. Slot k carries word bit k-32+W, so the LSB always lands in slot 31.
- R5: Word-length code 0, 1, 2, 3 selects W = 16, 18, 20, 24 bits. The word is the top W bits of the sample.
- R6: A slot whose bit position falls outside 0..W-1 is driven low.
- R7: Layout code 1 is reserved, and with it every data line is low.
- R8: While the channel-mode input is high, data line 2 is low. Lines 0 and 1 keep working.
- R9: While reset is asserted (rst_n low), all data lines are low. Reset is asynchronous.
- R10: The dither generator is a 16-bit register with seed 0xACE1. It shifts left and takes in the XOR of bits 15, 13, 12 and 10, and it steps once at the start of every left half. Line n takes dither bit 2n for its left word and bit 2n+1 for its right word, using the register value held just before the half-start edge.
- R11: With dither enabled, the dither bit is added at the LSB of the W-bit word. If the word is already the largest positive value, it stays there.
- R12: Each half start latches that half's word from the sample bus. Channel c = 2*line + (1 for right) is read from samples[24c+23:24c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | External bit clock |
| frame_clk | input | 1 | External frame clock |
| layout_sel | input | 2 | Bit layout select (0 LSB-justified, 1 reserved, 2 MSB-justified, 3 I2S) |
| wlen_sel | input | 2 | Word-length select (16/18/20/24) |
| quad_mode | input | 1 | High forces data line 2 low |
| dither_en | input | 1 | Enables LSB dither |
| samples | input | 144 | Six 24-bit samples, channel c at bits 24c+23:24c |
| sdata_o | output | 3 | Serial data lines |

## Verification
At the falling bit-clock edge that opens a left half, two things happen in the same cycle: the word is latched with the dither bit taken from the old generator state, and the generator steps. A mistake in the order of these two shows up as an error in the LSB of the word. The bench provokes this with dither enabled, random samples, and runs of the largest positive sample, so that saturation and the step also meet in that cycle. It judges the result by comparing every serial bit of every half frame against a model that reads the dither bit first and then advances the generator.

// File: rtl/audtx_pkg.sv
package audtx_pkg;
  parameter int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    LAY_LSBJ = 2'd0,
    LAY_RSVD = 2'd1,
    LAY_MSBJ = 2'd2,
    LAY_I2S  = 2'd3
  } layout_e;

  // word length from its select code
  function automatic int word_bits(logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

  // bit position (from MSB) carried by a slot; negative means none
  function automatic int slot_pos(logic [1:0] lay, int slot, int w, int half);
    case (lay)
      LAY_MSBJ: return slot;
      LAY_I2S:  return slot - 1;
      LAY_LSBJ: return slot - half + w;
      default:  return -1;
    endcase
  endfunction

  // truncate to w bits (left aligned) and add dither with saturation
  function automatic logic [SAMPLE_W-1:0] prep_word(logic [SAMPLE_W-1:0] s, int w, logic d);
    logic [SAMPLE_W-1:0] mask, t, inc, sum, top;
    mask = {SAMPLE_W{1'b1}} << (SAMPLE_W - w);
    t    = s & mask;
    inc  = d ? ({{(SAMPLE_W-1){1'b0}}, 1'b1} << (SAMPLE_W - w)) : '0;
    sum  = t + inc;
    top  = mask & {1'b0, {(SAMPLE_W-1){1'b1}}};
    return (!t[SAMPLE_W-1] && sum[SAMPLE_W-1]) ? top : sum;
  endfunction

  function automatic logic pick_bit(logic [SAMPLE_W-1:0] word, int p, int w);
    logic [SAMPLE_W-1:0] sh;
    if (p < 0 || p >= w) return 1'b0;
    sh = word << p;
    return sh[SAMPLE_W-1];
  endfunction
endpackage

// File: rtl/audtx_slot_track.sv
module audtx_slot_track #(
  parameter int HALF_SLOTS = 32,
  parameter int IDX_W      = $clog2(2*HALF_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_clk,
  input  logic             frame_clk,
  output logic             start_evt,
  output logic [IDX_W-1:0] idx_q
);
  localparam int SLOT_MAX = 2*HALF_SLOTS - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOT_MAX);

  logic bck_d, lrck_prev, fall_evt;

  assign fall_evt  = bck_d & ~bit_clk;
  assign start_evt = fall_evt & (frame_clk != lrck_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d     <= 1'b0;
      lrck_prev <= 1'b0;
      idx_q     <= LAST;
    end else begin
      bck_d <= bit_clk;
      if (fall_evt) begin
        lrck_prev <= frame_clk;
        if (start_evt)          idx_q <= '0;
        else if (idx_q != LAST) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(idx_q));
  // R2
  slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> idx_q == '0);
endmodule

// File: rtl/audtx_lfsr.sv
module audtx_lfsr #(
  parameter int               LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS  = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] q
);
  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (step) q <= {q[LFSR_W-2:0], fb};
  end

  // R10
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0);
endmodule

// File: rtl/audtx_lane.sv
module audtx_lane
  import audtx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                take_right,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  int                  w,
  input  logic                dith_en,
  input  logic                dbit_l,
  input  logic                dbit_r,
  input  int                  pos,
  input  logic                kill,
  output logic                sd_o
);
  logic [SAMPLE_W-1:0] word_q;
  logic                dbit;

  assign dbit = dith_en & (take_right ? dbit_r : dbit_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sd_o   <= 1'b0;
    end else begin
      if (capture) word_q <= prep_word(take_right ? smp_r : smp_l, w, dbit);
      sd_o <= kill ? 1'b0 : pick_bit(word_q, pos, w);
    end
  end
endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import audtx_pkg::*;
#(
  parameter int               NLINE      = 3,
  parameter int               HALF_SLOTS = 32,
  parameter int               LFSR_W     = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bit_clk,
  input  logic                        frame_clk,
  input  logic [1:0]                  layout_sel,
  input  logic [1:0]                  wlen_sel,
  input  logic                        quad_mode,
  input  logic                        dither_en,
  input  logic [2*NLINE*SAMPLE_W-1:0] samples,
  output logic [NLINE-1:0]            sdata_o
);
  localparam int IDX_W = $clog2(2*HALF_SLOTS);

  logic             start_evt, is_left, frame_go;
  logic [IDX_W-1:0] idx_q;
  logic [LFSR_W-1:0] lfsr_q;
  int               cur_w, pos_now;

  audtx_slot_track #(.HALF_SLOTS(HALF_SLOTS), .IDX_W(IDX_W)) u_track (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .start_evt(start_evt), .idx_q(idx_q));

  assign is_left  = (layout_sel == LAY_I2S) ? ~frame_clk : frame_clk;
  assign frame_go = start_evt & is_left;
  assign cur_w    = word_bits(wlen_sel);
  assign pos_now  = slot_pos(layout_sel, int'(idx_q), cur_w, HALF_SLOTS);

  audtx_lfsr #(.LFSR_W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(frame_go), .q(lfsr_q));

  for (genvar g = 0; g < NLINE; g++) begin : g_lane
    localparam bit LAST_LINE = (g == NLINE-1);
    logic sd;
    audtx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .capture(start_evt), .take_right(~is_left),
      .smp_l(samples[(2*g)*SAMPLE_W +: SAMPLE_W]),
      .smp_r(samples[(2*g+1)*SAMPLE_W +: SAMPLE_W]),
      .w(cur_w), .dith_en(dither_en),
      .dbit_l(lfsr_q[2*g]), .dbit_r(lfsr_q[2*g+1]),
      .pos(pos_now), .kill(quad_mode & LAST_LINE), .sd_o(sd));
    assign sdata_o[g] = sd;
  end

  // R9
  reset_low_chk: assert property (@(posedge clk) disable iff (rst_n)
    sdata_o == '0);
  // R8
  quad_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad_mode |=> !sdata_o[NLINE-1]);
  // R7
  rsvd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layout_sel == LAY_RSVD |=> sdata_o == '0);
endmodule

// File: tb/serial_audio_tx_bench.sv
module serial_audio_tx_bench;
  logic clk = 1'b0;
  logic rst_n, bck, lrck, quad, dith;
  logic [1:0] lay, wl;
  logic [143:0] smp_bus;
  logic [2:0] sdo;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_audio_tx u_serial_audio_tx (
    .clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(lrck),
    .layout_sel(lay), .wlen_sel(wl), .quad_mode(quad), .dither_en(dith),
    .samples(smp_bus), .sdata_o(sdo));

  // model state
  int m_slot;
  logic m_prev;
  logic [15:0] m_lfsr;
  int m_t [3];
  logic [31:0] got_v [3];
  logic [31:0] exp_v [3];

  function automatic int bw(logic [1:0] c);
    return (c == 0) ? 16 : (c == 1) ? 18 : (c == 2) ? 20 : 24;   // R5
  endfunction

  function automatic int bpos(logic [1:0] l, int s, int w);
    if (l == 2'd2) return s;            // R2
    if (l == 2'd3) return s - 1;        // R3
    if (l == 2'd0) return s + w - 32;   // R4
    return -100;                        // R7
  endfunction

  function automatic int btrunc(logic [23:0] s, int w, logic d);
    int v;
    v = int'($signed(s));
    v = v >>> (24 - w);
    if (d && v < ((1 << (w-1)) - 1)) v = v + 1;   // R11
    return v;
  endfunction

  function automatic logic bbit(int t, int w, int p);
    if (p < 0 || p >= w) return 1'b0;  // R6
    return 1'(t >>> (w - 1 - p));
  endfunction

  function automatic logic [15:0] bstep(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};   // R10
  endfunction

  task automatic model_reset();
    m_slot = 63; m_prev = 1'b0; m_lfsr = 16'hACE1;
    for (int i = 0; i < 3; i++) m_t[i] = 0;
  endtask

  task automatic do_slot(input logic lv, input int k);
    logic left;
    @(negedge clk);
    bck = 1'b0; lrck = lv;
    if (lv != m_prev) begin
      m_slot = 0;
      left = (lay == 2'd3) ? !lv : lv;
      for (int i = 0; i < 3; i++) begin  // R12
        int c;
        c = 2*i + (left ? 0 : 1);
        m_t[i] = btrunc(smp_bus[24*c +: 24], bw(wl), dith & m_lfsr[c]);
      end
      if (left) m_lfsr = bstep(m_lfsr);
    end else if (m_slot < 63) m_slot++;
    m_prev = lv;
    @(negedge clk); @(negedge clk);   // R1: update, then output register
    for (int i = 0; i < 3; i++) begin
      got_v[i][31-k] = sdo[i];
      exp_v[i][31-k] = (quad && i == 2) ? 1'b0 : bbit(m_t[i], bw(wl), bpos(lay, m_slot, bw(wl)));
    end
    bck = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  function automatic string tag_of(int line);
    if (quad && line == 2) return "R8";
    if (lay == 2'd1) return "R7";
    if (dith) return "R11";
    if (lay == 2'd2) return "R2";
    if (lay == 2'd3) return "R3";
    return "R4";
  endfunction

  task automatic run_frame(input logic [1:0] l, input logic [1:0] w, input logic q, input logic d);
    @(negedge clk);
    lay = l; wl = w; quad = q; dith = d;
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 32; k++) do_slot(h == 0, k);
      for (int i = 0; i < 3; i++) begin
        checks++;
        if (got_v[i] !== exp_v[i]) begin
          errors++;
          $display("FAIL %s line %0d half %0d lay=%0d wl=%0d: got %h expected %h",
                   tag_of(i), i, h, l, w, got_v[i], exp_v[i]);
        end
      end
    end
  endtask

  task automatic fill_all(input logic [23:0] v);
    for (int c = 0; c < 6; c++) smp_bus[24*c +: 24] = v;
  endtask

  task automatic fill_rand();
    for (int c = 0; c < 6; c++) begin
      int r;
      r = int'($urandom % 8);
      smp_bus[24*c +: 24] = (r == 0) ? 24'h7FFFFF : (r == 1) ? 24'h800000 : 24'($urandom);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int seed_v;
    seed_v = $urandom(32'h5EED);
    rst_n = 1'b0; bck = 1'b1; lrck = 1'b0; lay = 2'd2; wl = 2'd3;
    quad = 1'b0; dith = 1'b0; smp_bus = '0;
    model_reset();
    repeat (4) @(negedge clk);
    checks++;   // R9 reset state
    if (sdo !== 3'b000) begin errors++; $display("FAIL R9 reset: got %b expected 000", sdo); end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed: each layout and word length
    for (int c = 0; c < 6; c++) smp_bus[24*c +: 24] = 24'hA5C3E1 ^ 24'(c * 24'h111111);
    run_frame(2'd2, 2'd3, 1'b0, 1'b0);   // R2
    run_frame(2'd3, 2'd3, 1'b0, 1'b0);   // R3
    run_frame(2'd0, 2'd0, 1'b0, 1'b0);   // R4 R5 R6
    run_frame(2'd0, 2'd1, 1'b0, 1'b0);
    run_frame(2'd2, 2'd2, 1'b0, 1'b0);   // R5
    run_frame(2'd1, 2'd3, 1'b0, 1'b0);   // R7
    run_frame(2'd2, 2'd3, 1'b1, 1'b0);   // R8
    // saturation with dither at frame boundaries
    fill_all(24'h7FFFFF);
    for (int n = 0; n < 6; n++) run_frame(2'(n % 2 == 0 ? 2 : 3), 2'(n % 4), 1'b0, 1'b1);   // R10 R11
    fill_all(24'h800000);
    run_frame(2'd0, 2'd3, 1'b0, 1'b1);

    // reset in the middle of a frame
    fill_all(24'h800000);
    lay = 2'd2; wl = 2'd3; quad = 1'b0; dith = 1'b0;
    @(negedge clk); bck = 1'b1;
    do_slot(1'b1, 0);
    checks++;   // R2 MSB in slot 0
    if (sdo !== 3'b111) begin errors++; $display("FAIL R2 first slot: got %b expected 111", sdo); end
    @(negedge clk); rst_n = 1'b0; #2;
    checks++;   // R9 asynchronous clear
    if (sdo !== 3'b000) begin errors++; $display("FAIL R9 mid-frame reset: got %b expected 000", sdo); end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // random mix
    for (int n = 0; n < 100; n++) begin
      fill_rand();
      run_frame(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 4 == 0), 1'($urandom % 2));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule